// File: doc/BRIEF.md
# Fixed-Block Event Telemetry Framer

This block turns a stream of spectral records into a byte stream cut into blocks of exactly 256 bytes. A record is announced on a header handshake that carries the record's field values. The framer places a 13-byte header in front of the record's payload. In the hardware-only mode the header is replaced by a bare two-byte FF,FF sync pair. The framer then pulls the payload bytes from a byte source that uses valid/ready.

Three event strobes insert typed 4-byte markers into the stream:
- Night entry emits FF,FF,FA,FA.
- Radiation-belt entry emits FF,FF,FB,FB.
- Mode-block start emits FF,FF,FE,FE.

After a night or belt marker, the framer suspends. It accepts no more records until a resume strobe arrives.

The downstream reader offers one byte slot per cycle on `slot`. When a block has been started and nothing is ready to send, the framer pads the block with F9 hex. This padding also happens in the middle of a record if the payload source runs dry. Each emitted byte appears on the registered output one cycle after its slot, and a flag marks byte 0 of every block.

Top module: `tlm_block_framer`

## Requirements
- R1: During and right after synchronous reset, `out_valid`, `out_sob`, `hdr_ready` and `rec_ready` are low, and the first byte emitted afterwards starts a block.
- R2: A normal record begins with 13 bytes, in this order: FF, FF, start-time low, start-time high, DP flags, unit flags, repeat count, tally, plan ID, integration time, length byte, length-high byte, control byte.
- R3: The length-minus-one value is 10 bits wide. Its bits 7:0 go in header byte 10, and its bits 9:8 go in bits 1:0 of byte 11, with bits 7:2 of byte 11 sent as zero. Exactly length-minus-one plus 1 payload bytes (1 to 1024) follow the header. `hdr_ready` and `rec_ready` are never high together.
- R4: When `hw_mode` is high at header acceptance, the record is preceded by only FF, FF, followed directly by its payload.
- R5: The output is cut into 256-byte blocks, and `out_sob` is high exactly on byte 0 of each block.
- R6: A granted slot in which no content is available, while a block is partly filled, emits F9. This includes a payload slot with `rec_valid` low, and the record then continues in a later slot.
- R7: When the current block is complete and nothing is pending, the framer emits no byte.
- R8: A night event emits FF,FF,FA,FA. After its last byte the framer is suspended: it fills the rest of the block with F9 and keeps `hdr_ready` low until `resume`.
- R9: A belt event emits FF,FF,FB,FB and also suspends. When night and belt arrive together, only the night marker is sent, and entering suspension discards every other pending event.
- R10: A mode-block event emits FF,FF,FE,FE and does not suspend, so records continue after it.
- R11: An event that arrives while a header, payload or marker is in progress is held. Its marker goes out only after the current record or marker completes, and a marker in progress is never split.
- R12: Event strobes that arrive while the framer is suspended are ignored and produce no marker after resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot | input | 1 | Reader grants one output byte slot this cycle |
| hw_mode | input | 1 | Hardware-only framing for the record being accepted |
| hdr_valid | input | 1 | A record header is offered |
| hdr_ready | output | 1 | Header accepted this cycle when valid |
| hdr_time | input | 16 | Record start time |
| hdr_dp_flags | input | 8 | DP flag byte |
| hdr_unit_flags | input | 8 | Unit flag byte |
| hdr_repeat | input | 8 | Repeat counter |
| hdr_tally | input | 8 | Tally value |
| hdr_plan | input | 8 | Plan ID |
| hdr_integ | input | 8 | Integration time |
| hdr_len_m1 | input | 10 | Payload length minus one |
| hdr_ctrl | input | 8 | Control byte |
| rec_valid | input | 1 | Payload byte available |
| rec_ready | output | 1 | Payload byte taken this cycle when valid |
| rec_data | input | 8 | Payload byte |
| night_evt | input | 1 | Night-entry strobe |
| belt_evt | input | 1 | Radiation-belt entry strobe |
| mib_evt | input | 1 | Mode-block start strobe |
| resume | input | 1 | Leave the suspended state |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sob | output | 1 | Output byte is byte 0 of a block |

## Verification
The main framing is exercised with several input patterns:
- A short full-header record, a short hardware-mode record and a back-to-back pair at the extreme lengths 1024 and 1 separate header layout, length packing and multi-block cutting.
- Running the same kind of record with slots granted only every other cycle shows that pacing changes timing but not content.
- A payload source with periodic gaps must produce the same stream once the F9 bytes are removed, with some fill landing inside the record. This tells mid-record padding apart from end-of-block padding.

Events are tested in three positions: at idle, during a header and during payload. They are also tested coinciding with each other and arriving while suspended. These cases separate the priority rule, the deferral rule and the rule that suspended events are dropped.

// File: rtl/tbf_pkg.sv
package tbf_pkg;

    localparam int BYTE_W       = 8;
    localparam int LEN_W        = 10;
    localparam int HDR_BYTES    = 13;
    localparam int HW_HDR_BYTES = 2;
    localparam int MARK_BYTES   = 4;
    localparam int IDX_W        = $clog2(HDR_BYTES);
    localparam int NUM_EVT      = 3;

    localparam logic [BYTE_W-1:0] SYNC_BYTE  = 8'hFF;
    localparam logic [BYTE_W-1:0] CODE_NIGHT = 8'hFA;
    localparam logic [BYTE_W-1:0] CODE_BELT  = 8'hFB;
    localparam logic [BYTE_W-1:0] CODE_MIB   = 8'hFE;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HDR,
        PH_DATA,
        PH_MARK
    } phase_t;

    typedef enum logic [1:0] {
        MK_NONE,
        MK_NIGHT,
        MK_BELT,
        MK_MIB
    } mark_t;

    typedef struct packed {
        logic [15:0]       t0;
        logic [BYTE_W-1:0] dpf;
        logic [BYTE_W-1:0] unf;
        logic [BYTE_W-1:0] rep;
        logic [BYTE_W-1:0] tally;
        logic [BYTE_W-1:0] plan;
        logic [BYTE_W-1:0] integ;
        logic [LEN_W-1:0]  len_m1;
        logic [BYTE_W-1:0] ctrl;
    } hdr_t;

    function automatic logic [BYTE_W-1:0] mark_code(mark_t k);
        case (k)
            MK_NIGHT: return CODE_NIGHT;
            MK_BELT:  return CODE_BELT;
            MK_MIB:   return CODE_MIB;
            default:  return SYNC_BYTE;
        endcase
    endfunction

    function automatic logic is_suspend(mark_t k);
        return (k == MK_NIGHT) || (k == MK_BELT);
    endfunction

    // Header byte selected by its position in the 13-byte header.
    function automatic logic [BYTE_W-1:0] hdr_byte(hdr_t h, logic [IDX_W-1:0] i);
        logic [15:0] len_w;
        len_w = 16'(h.len_m1);
        case (i)
            4'd2:    return h.t0[7:0];
            4'd3:    return h.t0[15:8];
            4'd4:    return h.dpf;
            4'd5:    return h.unf;
            4'd6:    return h.rep;
            4'd7:    return h.tally;
            4'd8:    return h.plan;
            4'd9:    return h.integ;
            4'd10:   return len_w[7:0];
            4'd11:   return len_w[15:8];
            4'd12:   return h.ctrl;
            default: return SYNC_BYTE;
        endcase
    endfunction

endpackage

// File: rtl/tbf_evt_latch.sv
module tbf_evt_latch
    import tbf_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  night_evt,
    input  logic  belt_evt,
    input  logic  mib_evt,
    input  logic  block,
    input  logic  take,
    input  logic  drop,
    output logic  pend_any,
    output mark_t pend_kind
);

    // bit 0 night, bit 1 belt, bit 2 mode block; lower index wins
    logic [NUM_EVT-1:0] pend_q, pend_d, raise, grant;

    assign raise = {mib_evt, belt_evt, night_evt};

    always_comb begin
        grant = '0;
        for (int i = 0; i < NUM_EVT; i++) begin
            if (pend_q[i] && (grant == '0)) grant[i] = 1'b1;
        end
    end

    always_comb begin
        if (grant[0])      pend_kind = MK_NIGHT;
        else if (grant[1]) pend_kind = MK_BELT;
        else if (grant[2]) pend_kind = MK_MIB;
        else               pend_kind = MK_NONE;
    end

    assign pend_any = |pend_q;

    always_comb begin
        pend_d = pend_q;
        if (take)   pend_d = pend_d & ~grant;
        if (!block) pend_d = pend_d | raise;
        if (drop)   pend_d = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= pend_d;
    end

    // R12: nothing new becomes pending while suspended
    p_no_new_when_susp_r12: assert property (@(posedge clk) disable iff (rst)
        block |=> ((pend_q & ~$past(pend_q)) == '0));

    // R9: a marker is only started for a held event
    p_take_has_event_r9: assert property (@(posedge clk) disable iff (rst)
        take |-> (pend_q != '0));

endmodule

// File: rtl/tbf_blk_ctr.sv
module tbf_blk_ctr #(
    parameter int BLOCK_BYTES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    output logic at_start
);

    localparam int  CNT_W = (BLOCK_BYTES > 1) ? $clog2(BLOCK_BYTES) : 1;
    localparam bit  POW2  = ((BLOCK_BYTES & (BLOCK_BYTES - 1)) == 0);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BLOCK_BYTES - 1);

    logic [CNT_W-1:0] cnt_q;

    generate
        if (POW2) begin : g_pow2
            always_ff @(posedge clk) begin
                if (rst)      cnt_q <= '0;
                else if (adv) cnt_q <= cnt_q + CNT_W'(1);
            end
        end else begin : g_cmp
            always_ff @(posedge clk) begin
                if (rst)      cnt_q <= '0;
                else if (adv) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
            end
        end
    endgenerate

    assign at_start = (cnt_q == '0);

    // R5: the last byte of a block is followed by byte 0
    p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
        (adv && (cnt_q == LAST)) |=> (cnt_q == '0));

    // R5: position only moves on an emitted byte
    p_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(cnt_q));

endmodule

// File: rtl/tbf_byte_gen.sv
module tbf_byte_gen
    import tbf_pkg::*;
#(
    parameter logic [7:0] FILL_BYTE = 8'hF9
) (
    input  phase_t            ph,
    input  logic              item_start,
    input  logic [IDX_W-1:0]  idx,
    input  hdr_t              hdr,
    input  mark_t             kind,
    input  logic [BYTE_W-1:0] data,
    input  logic              data_ok,
    output logic [BYTE_W-1:0] byte_o
);

    always_comb begin
        case (ph)
            PH_IDLE: byte_o = item_start ? SYNC_BYTE : FILL_BYTE;
            PH_HDR:  byte_o = hdr_byte(hdr, idx);
            PH_DATA: byte_o = data_ok ? data : FILL_BYTE;
            PH_MARK: byte_o = (idx < IDX_W'(2)) ? SYNC_BYTE : mark_code(kind);
            default: byte_o = FILL_BYTE;
        endcase
    end

endmodule

// File: rtl/tlm_block_framer.sv
module tlm_block_framer
    import tbf_pkg::*;
#(
    parameter int         BLOCK_BYTES = 256,
    parameter logic [7:0] FILL_BYTE   = 8'hF9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot,
    input  logic              hw_mode,
    input  logic              hdr_valid,
    output logic              hdr_ready,
    input  logic [15:0]       hdr_time,
    input  logic [7:0]        hdr_dp_flags,
    input  logic [7:0]        hdr_unit_flags,
    input  logic [7:0]        hdr_repeat,
    input  logic [7:0]        hdr_tally,
    input  logic [7:0]        hdr_plan,
    input  logic [7:0]        hdr_integ,
    input  logic [LEN_W-1:0]  hdr_len_m1,
    input  logic [7:0]        hdr_ctrl,
    input  logic              rec_valid,
    output logic              rec_ready,
    input  logic [7:0]        rec_data,
    input  logic              night_evt,
    input  logic              belt_evt,
    input  logic              mib_evt,
    input  logic              resume,
    output logic              out_valid,
    output logic [7:0]        out_data,
    output logic              out_sob
);

    localparam logic [IDX_W-1:0] HDR_LAST  = IDX_W'(HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] HW_LAST   = IDX_W'(HW_HDR_BYTES - 1);
    localparam logic [IDX_W-1:0] MARK_LAST = IDX_W'(MARK_BYTES - 1);

    phase_t            st_q, st_d;
    logic [IDX_W-1:0]  idx_q, idx_d;
    logic [LEN_W-1:0]  dcnt_q, dcnt_d;
    hdr_t              hdr_q, hdr_d, hdr_in;
    logic              hw_q, hw_d;
    mark_t             kind_q, kind_d;
    logic              susp_q, susp_set;
    logic              pend_any;
    mark_t             pend_kind;
    logic              mark_take;
    logic              emit, item_start, data_ok;
    logic              blk_at_start;
    logic [7:0]        gen_byte;

    assign hdr_in = '{t0:     hdr_time,
                      dpf:    hdr_dp_flags,
                      unf:    hdr_unit_flags,
                      rep:    hdr_repeat,
                      tally:  hdr_tally,
                      plan:   hdr_plan,
                      integ:  hdr_integ,
                      len_m1: hdr_len_m1,
                      ctrl:   hdr_ctrl};

    tbf_evt_latch u_evt (
        .clk       (clk),
        .rst       (rst),
        .night_evt (night_evt),
        .belt_evt  (belt_evt),
        .mib_evt   (mib_evt),
        .block     (susp_q),
        .take      (mark_take),
        .drop      (susp_set),
        .pend_any  (pend_any),
        .pend_kind (pend_kind)
    );

    tbf_blk_ctr #(.BLOCK_BYTES(BLOCK_BYTES)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .adv      (emit),
        .at_start (blk_at_start)
    );

    tbf_byte_gen #(.FILL_BYTE(FILL_BYTE)) u_gen (
        .ph         (st_q),
        .item_start (item_start),
        .idx        (idx_q),
        .hdr        (hdr_q),
        .kind       (kind_q),
        .data       (rec_data),
        .data_ok    (data_ok),
        .byte_o     (gen_byte)
    );

    // One byte decision per granted slot.
    always_comb begin
        st_d       = st_q;
        idx_d      = idx_q;
        dcnt_d     = dcnt_q;
        hdr_d      = hdr_q;
        hw_d       = hw_q;
        kind_d     = kind_q;
        emit       = 1'b0;
        item_start = 1'b0;
        mark_take  = 1'b0;
        susp_set   = 1'b0;
        data_ok    = 1'b0;
        hdr_ready  = 1'b0;
        rec_ready  = 1'b0;
        if (slot) begin
            case (st_q)
                PH_IDLE: begin
                    hdr_ready = !susp_q && !pend_any;
                    if (!susp_q && pend_any) begin
                        emit       = 1'b1;
                        item_start = 1'b1;
                        mark_take  = 1'b1;
                        kind_d     = pend_kind;
                        st_d       = PH_MARK;
                        idx_d      = IDX_W'(1);
                    end else if (hdr_ready && hdr_valid) begin
                        emit       = 1'b1;
                        item_start = 1'b1;
                        hdr_d      = hdr_in;
                        hw_d       = hw_mode;
                        st_d       = PH_HDR;
                        idx_d      = IDX_W'(1);
                    end else if (!blk_at_start) begin
                        emit = 1'b1;
                    end
                end
                PH_HDR: begin
                    emit = 1'b1;
                    if (idx_q == (hw_q ? HW_LAST : HDR_LAST)) begin
                        st_d   = PH_DATA;
                        idx_d  = '0;
                        dcnt_d = '0;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
                PH_DATA: begin
                    rec_ready = 1'b1;
                    emit      = 1'b1;
                    if (rec_valid) begin
                        data_ok = 1'b1;
                        if (dcnt_q == hdr_q.len_m1) st_d = PH_IDLE;
                        else                        dcnt_d = dcnt_q + LEN_W'(1);
                    end
                end
                PH_MARK: begin
                    emit = 1'b1;
                    if (idx_q == MARK_LAST) begin
                        st_d  = PH_IDLE;
                        idx_d = '0;
                        if (is_suspend(kind_q)) susp_set = 1'b1;
                    end else begin
                        idx_d = idx_q + IDX_W'(1);
                    end
                end
                default: st_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= PH_IDLE;
            idx_q     <= '0;
            dcnt_q    <= '0;
            hdr_q     <= '0;
            hw_q      <= 1'b0;
            kind_q    <= MK_NONE;
            susp_q    <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sob   <= 1'b0;
        end else begin
            st_q      <= st_d;
            idx_q     <= idx_d;
            dcnt_q    <= dcnt_d;
            hdr_q     <= hdr_d;
            hw_q      <= hw_d;
            kind_q    <= kind_d;
            if (susp_set)    susp_q <= 1'b1;
            else if (resume) susp_q <= 1'b0;
            out_valid <= emit;
            out_data  <= gen_byte;
            out_sob   <= emit && blk_at_start;
        end
    end

    // R8: no record is taken while suspended
    p_susp_blocks_hdr_r8: assert property (@(posedge clk) disable iff (rst)
        susp_q |-> !hdr_ready);

    // R11: a marker holds its place until its next slot
    p_mark_whole_r11: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_MARK && !slot) |=> (st_q == PH_MARK && $stable(idx_q)));

    // R3: the two handshakes never overlap
    p_ready_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(hdr_ready && rec_ready));

    // R3: payload count stays within the captured length
    p_len_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (st_q == PH_DATA) |-> (dcnt_q <= hdr_q.len_m1));

endmodule

// File: tb/tlm_block_framer_bench.sv
module tlm_block_framer_bench;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, slot, hw_mode, hdr_valid, hdr_ready;
    logic [15:0] hdr_time;
    logic [7:0]  hdr_dp_flags, hdr_unit_flags, hdr_repeat, hdr_tally;
    logic [7:0]  hdr_plan, hdr_integ, hdr_ctrl;
    logic [9:0]  hdr_len_m1;
    logic        rec_valid, rec_ready;
    logic [7:0]  rec_data;
    logic        night_evt, belt_evt, mib_evt, resume;
    logic        out_valid, out_sob;
    logic [7:0]  out_data;

    tlm_block_framer u_tlm_block_framer (
        .clk(clk), .rst(rst), .slot(slot), .hw_mode(hw_mode),
        .hdr_valid(hdr_valid), .hdr_ready(hdr_ready), .hdr_time(hdr_time),
        .hdr_dp_flags(hdr_dp_flags), .hdr_unit_flags(hdr_unit_flags),
        .hdr_repeat(hdr_repeat), .hdr_tally(hdr_tally), .hdr_plan(hdr_plan),
        .hdr_integ(hdr_integ), .hdr_len_m1(hdr_len_m1), .hdr_ctrl(hdr_ctrl),
        .rec_valid(rec_valid), .rec_ready(rec_ready), .rec_data(rec_data),
        .night_evt(night_evt), .belt_evt(belt_evt), .mib_evt(mib_evt),
        .resume(resume), .out_valid(out_valid), .out_data(out_data),
        .out_sob(out_sob)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] d_time [8];
    logic [9:0]  d_len  [8];
    logic        d_hw   [8];
    int rec_n = 0, rec_i = 0;
    int g = 0, eg = 0;
    int slot_mode = 2;
    int gap_en = 0;
    int cyc = 0;
    bit hdr_fire = 0, data_fire = 0;

    logic [7:0] cap_d [2048];
    logic       cap_s [2048];
    int cap_n = 0;
    logic [7:0] exp_d [2048];
    int exp_n = 0;

    function automatic logic [7:0] dval(int k);
        return 8'((k * 3 + 1) & 127);
    endfunction
    function automatic logic [7:0] fld(int i, int salt);
        return 8'((d_time[i][7:0] + salt * 11) & 127);
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic new_test();
        cap_n = 0; exp_n = 0; rec_n = 0; rec_i = 0; eg = g;
    endtask

    task automatic add_rec(logic [15:0] tm, int len_m1, logic hw);
        d_time[rec_n] = tm; d_len[rec_n] = 10'(len_m1); d_hw[rec_n] = hw;
        rec_n++;
    endtask

    task automatic e_push(logic [7:0] b);
        exp_d[exp_n] = b; exp_n++;
    endtask

    task automatic e_hdr(int i);
        e_push(8'hFF); e_push(8'hFF);
        if (!d_hw[i]) begin
            e_push(d_time[i][7:0]); e_push(d_time[i][15:8]);
            e_push(fld(i, 1)); e_push(fld(i, 2)); e_push(fld(i, 3));
            e_push(fld(i, 4)); e_push(fld(i, 5)); e_push(fld(i, 6));
            e_push(8'(int'(d_len[i]) % 256));
            e_push(8'((int'(d_len[i]) / 256) % 4));
            e_push(fld(i, 7));
        end
    endtask

    task automatic e_data(int n);
        for (int k = 0; k < n; k++) begin e_push(dval(eg)); eg++; end
    endtask

    task automatic e_mark(logic [7:0] code);
        e_push(8'hFF); e_push(8'hFF); e_push(code); e_push(code);
    endtask

    task automatic e_pad();
        while (exp_n % 256 != 0) e_push(8'hF9);
    endtask

    task automatic cmp_stream(string req);
        int mis;
        mis = -1;
        chk(cap_n == exp_n, req, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++)
            if (mis < 0 && cap_d[i] != exp_d[i]) mis = i;
        if (mis >= 0) chk(0, req, cap_d[mis], exp_d[mis]);
        else          chk(1, req, 0, 0);
    endtask

    task automatic chk_sob();
        int bad;
        bad = -1;
        for (int i = 0; i < cap_n; i++)
            if (bad < 0 && cap_s[i] != (i % 256 == 0)) bad = i;
        chk(bad < 0, "R5 sob position", bad, -1);
    endtask

    task automatic pulse(int which);
        case (which)
            0: night_evt = 1'b1;
            1: belt_evt  = 1'b1;
            2: mib_evt   = 1'b1;
            default: resume = 1'b1;
        endcase
        tick(1);
        night_evt = 0; belt_evt = 0; mib_evt = 0; resume = 0;
    endtask

    // stimulus driver for slot, header and payload source
    initial begin
        slot = 0; hdr_valid = 0; hw_mode = 0; rec_valid = 0; rec_data = 0;
        hdr_time = 0; hdr_dp_flags = 0; hdr_unit_flags = 0; hdr_repeat = 0;
        hdr_tally = 0; hdr_plan = 0; hdr_integ = 0; hdr_len_m1 = 0; hdr_ctrl = 0;
        forever begin
            @(negedge clk);
            cyc++;
            if (hdr_fire)  rec_i++;
            if (data_fire) g++;
            slot = (slot_mode == 0) ? 1'b1 : ((slot_mode == 1) ? cyc[0] : 1'b0);
            if (rec_i < rec_n) begin
                hdr_valid      = 1'b1;
                hw_mode        = d_hw[rec_i];
                hdr_time       = d_time[rec_i];
                hdr_dp_flags   = fld(rec_i, 1);
                hdr_unit_flags = fld(rec_i, 2);
                hdr_repeat     = fld(rec_i, 3);
                hdr_tally      = fld(rec_i, 4);
                hdr_plan       = fld(rec_i, 5);
                hdr_integ      = fld(rec_i, 6);
                hdr_len_m1     = d_len[rec_i];
                hdr_ctrl       = fld(rec_i, 7);
            end else begin
                hdr_valid = 1'b0;
            end
            rec_valid = !(gap_en != 0 && (cyc % 7 == 3));
            rec_data  = dval(g);
            #1;
            hdr_fire  = hdr_valid && hdr_ready;
            data_fire = rec_valid && rec_ready;
        end
    end

    // output monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid && cap_n < 2048) begin
                cap_d[cap_n] = out_data; cap_s[cap_n] = out_sob; cap_n++;
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int strip_n, last_nf, inner;
        logic [7:0] strip [2048];
        night_evt = 0; belt_evt = 0; mib_evt = 0; resume = 0;
        rst = 1;
        tick(5);
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(out_sob == 0, "R1 out_sob", out_sob, 0);
        chk(hdr_ready == 0 && rec_ready == 0, "R1 ready", {hdr_ready, rec_ready}, 0);
        rst = 0;
        slot_mode = 0;
        tick(20);
        // R7 idle: no bytes with nothing pending
        chk(cap_n == 0, "R7 idle output", cap_n, 0);
        chk(hdr_ready == 1, "R7 idle accepting", hdr_ready, 1);

        // R2 R3 R5 R6: short full-header record
        new_test();
        add_rec(16'h1234, 19, 0);
        tick(320);
        e_hdr(0); e_data(20); e_pad();
        cmp_stream("R2 short record");
        chk(cap_n > 0 && cap_s[0] == 1, "R1 first byte starts block", cap_s[0], 1);
        chk(cap_n == 256 && cap_d[255] == 8'hF9, "R6 end pad", cap_d[255], 8'hF9);
        chk_sob();

        // R4: hardware-mode record with half-rate slots
        new_test();
        slot_mode = 1;
        add_rec(16'h0506, 4, 1);
        tick(600);
        e_hdr(0); e_data(5); e_pad();
        cmp_stream("R4 hw mode half rate");
        slot_mode = 0;

        // R3 R5: length extremes back to back
        new_test();
        add_rec(16'h0A0B, 1023, 0);
        add_rec(16'h0C0D, 0, 0);
        tick(1400);
        e_hdr(0); e_data(1024); e_hdr(1); e_data(1); e_pad();
        cmp_stream("R3 length extremes");
        chk(cap_d[10] == 8'hFF && cap_d[11] == 8'h03, "R3 len 1024 bytes",
            {cap_d[10], cap_d[11]}, 16'hFF03);
        chk(cap_d[1047] == 8'h00 && cap_d[1048] == 8'h00, "R3 len 1 bytes",
            {cap_d[1047], cap_d[1048]}, 0);
        chk(cap_n == 1280, "R5 block count", cap_n, 1280);
        chk_sob();

        // R6: payload gaps give fill inside the record
        new_test();
        gap_en = 1;
        add_rec(16'h2122, 299, 0);
        tick(700);
        gap_en = 0;
        e_hdr(0); e_data(300);
        strip_n = 0; last_nf = 0;
        for (int i = 0; i < cap_n; i++)
            if (cap_d[i] != 8'hF9) begin strip[strip_n] = cap_d[i]; strip_n++; last_nf = i; end
        inner = 0;
        for (int i = 0; i < last_nf; i++) if (cap_d[i] == 8'hF9) inner++;
        chk(strip_n == exp_n, "R6 content count", strip_n, exp_n);
        begin
            int mis;
            mis = -1;
            for (int i = 0; i < exp_n && i < strip_n; i++)
                if (mis < 0 && strip[i] != exp_d[i]) mis = i;
            chk(mis < 0, "R6 content order", mis, -1);
        end
        chk(inner > 0, "R6 fill inside record", inner, 1);
        chk(cap_n % 256 == 0, "R5 padded gap block", cap_n, 512);
        chk_sob();

        // R8 R12: night at idle, suspension, ignored events, resume
        new_test();
        pulse(0);
        tick(300);
        e_mark(8'hFA); e_pad();
        cmp_stream("R8 night marker");
        add_rec(16'h0203, 7, 0);
        tick(40);
        chk(cap_n == 256, "R8 suspended no output", cap_n, 256);
        chk(hdr_ready == 0, "R8 suspended hdr_ready", hdr_ready, 0);
        pulse(1); pulse(2); pulse(0);
        tick(5);
        pulse(3);
        tick(300);
        e_hdr(0); e_data(8); e_pad();
        cmp_stream("R12 no marker after resume");
        chk(cap_d[258] == 8'h03, "R12 record follows", cap_d[258], 8'h03);

        // R9: coincident night and belt, then belt alone
        new_test();
        night_evt = 1; belt_evt = 1;
        tick(1);
        night_evt = 0; belt_evt = 0;
        tick(300);
        pulse(3);
        tick(3);
        pulse(1);
        tick(300);
        e_mark(8'hFA); e_pad(); e_mark(8'hFB); e_pad();
        cmp_stream("R9 priority and belt");
        chk(hdr_ready == 0, "R9 belt suspends", hdr_ready, 0);
        pulse(3);
        tick(3);

        // R10 R11: mode-block event during a header, no suspension
        new_test();
        add_rec(16'h3132, 29, 0);
        add_rec(16'h3334, 9, 0);
        tick(3);
        pulse(2);
        tick(320);
        e_hdr(0); e_data(30); e_mark(8'hFE); e_hdr(1); e_data(10); e_pad();
        cmp_stream("R10 R11 deferred mode-block marker");

        // R11: night during payload waits for record end
        new_test();
        add_rec(16'h4142, 39, 0);
        tick(20);
        pulse(0);
        tick(320);
        e_hdr(0); e_data(40); e_mark(8'hFA); e_pad();
        cmp_stream("R11 night after record");
        chk(hdr_ready == 0, "R8 suspended after record", hdr_ready, 0);
        pulse(3);
        tick(3);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule